// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and calendar date as packed BCD digits: seconds, minutes, hours, a weekday index, day of month, month, and a three-digit year offset. A prescaler divides the reference clock by a parameter, `DIV`, which defaults to 32768. Each time the prescaler completes a count, it produces a one-cycle strobe. Every strobe moves the time forward by one second, carrying through minutes, hours, days, months and years. Day-of-month rollover follows real month lengths, and February follows the full Gregorian leap-year rule. The leap-year rule is applied to the stored year offset plus 1900.

Software reads any field by placing its code on a read select. It changes a field by pulsing a write enable with a select and data. Writes take effect only while the master enable is high. When the master enable is low, the prescaler is held cleared and the time is frozen. The strobe is also brought out of the block so that an alarm comparator can be attached outside it. Because all fields are kept in BCD, reads need no conversion.

Top module: `bcd_calendar`

## Requirements
- R1: While `enable_i` is high, `sec_tick_o` is high for exactly one cycle every `DIV` clock cycles. The first strobe comes `DIV` cycles after `enable_i` is first sampled high. No strobe occurs while `enable_i` is low, and the prescaler restarts from zero on each rising edge of the enable.
- R2: On each strobe, seconds step in BCD. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and signal a new day.
- R3: On each new day, the weekday field steps through 0..6 and then returns to 0.
- R4: The day-of-month limit is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. For month 2 the limit is 28, or 29 when Y = offset+1900 is divisible by 4 and is either not divisible by 100 or divisible by 400.
- R5: On a new day where the day of month is at or above its limit, the day becomes 1 and the month steps. A step past month 12 sets the month to 1 and steps the year. The year offset wraps from 999 to 000.
- R6: Select codes are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year. Code 7 reads as zero and accepts no write. Two-digit fields sit in bits [7:0] as tens:units nibbles. The month is 1-based (01..12). The year uses bits [11:8] for the hundreds digit and bits [7:0] for the tens and units. Write data is masked to 7 bits for seconds and minutes, 6 bits for hours and day of month, 5 bits for month, 3 bits for weekday, and 12 bits for year.
- R7: While `enable_i` is low, writes are discarded and no field changes.
- R8: If a write lands on the same clock edge as a strobe, the written field takes the written value and not its incremented value.
- R9: After reset, the time reads 00:00:00, weekday 0, day 01, month 01, year 000, and `sec_tick_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Master enable: runs the prescaler and allows writes |
| wr_en_i | input | 1 | Write strobe for the selected field |
| wr_sel_i | input | 3 | Field code for writes |
| wr_data_i | input | 12 | BCD write data |
| rd_sel_i | input | 3 | Field code for reads |
| rd_data_o | output | 12 | BCD value of the selected field (combinational) |
| sec_tick_o | output | 1 | One-cycle strobe per elapsed second |

## Verification
The bench uses a small divider of 16. It first runs an unbroken stretch of more than an hour of seconds from midnight. This run separates the units/tens digit carries from the minute and hour wraps. Next, it places the clock at 23:59:59 on the last day of every month, across a set of year offsets. These offsets cover a plain year, century years with and without the 400 rule, a leap year inside a century, and the 999 wrap. This sweep separates the four month lengths and the year carry. It also places the clock on 28 February of the same years, to separate 28-day from 29-day Februaries. A run of consecutive day ends shows the weekday wrap. Targeted cases measure the strobe spacing after enable rises, show that a frozen clock ignores writes, and show that a write wins over a coincident increment.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_WDAY = 3'd3,
    F_MDAY = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6,
    F_NONE = 3'd7
  } field_e;

  localparam int DATA_W = 12;

  function automatic logic [7:0] bcd2_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [11:0] bcd3_inc(input logic [11:0] v);
    if (v[7:0] == 8'h99) return {(v[11:8] >= 4'd9) ? 4'd0 : v[11:8] + 4'd1, 8'h00};
    return {v[11:8], bcd2_inc(v[7:0])};
  endfunction

  // offset+1900: 1900 is a multiple of 4, and a century year is a multiple of 400
  // exactly when its hundreds digit mod 4 equals 1.
  function automatic logic is_leap(input logic [11:0] y);
    logic [6:0] lo_bin;
    lo_bin = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    return (lo_bin[1:0] == 2'b00) && ((y[7:0] != 8'h00) || (y[9:8] == 2'b01));
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_cal_prescaler.sv
module bcd_cal_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bcd_cal_wrap_cnt.sv
module bcd_cal_wrap_cnt
  import bcd_cal_pkg::*;
#(
  parameter field_e     SEL   = F_SEC,
  parameter logic [7:0] WMASK = 8'h7F,
  parameter logic [7:0] WRAPV = 8'h00,
  parameter logic [7:0] RSTV  = 8'h00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        inc_i,
  input  logic [7:0]  lim_i,
  input  logic        wr_i,
  input  field_e      wr_sel_i,
  input  logic [7:0]  wr_data_i,
  output logic [7:0]  val_o,
  output logic        carry_o
);
  logic hit;

  assign hit     = wr_i && (wr_sel_i == SEL);
  // >= so an out-of-range written value still wraps
  assign carry_o = inc_i && (val_o >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_o <= RSTV;
    else if (hit)    val_o <= wr_data_i & WMASK;
    else if (inc_i)  val_o <= carry_o ? WRAPV : bcd2_inc(val_o);
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter int DIV = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sec_tick_o
);
  logic        wr_ok;
  field_e      wsel;
  logic [7:0]  sec_w, min_w, hour_w, wday_w, mday_w, mon_w;
  logic [11:0] year_q;
  logic        sec_c, min_c, hour_c, wday_c, mday_c, mon_c;
  logic [7:0]  mday_lim;

  assign wr_ok    = wr_en_i && enable_i;
  assign wsel     = field_e'(wr_sel_i);
  assign mday_lim = month_len(mon_w, is_leap(year_q));

  bcd_cal_prescaler #(.DIV(DIV)) u_presc (
    .clk_i, .rst_ni, .run_i(enable_i), .tick_o(sec_tick_o)
  );

  bcd_cal_wrap_cnt #(.SEL(F_SEC), .WMASK(8'h7F), .WRAPV(8'h00), .RSTV(8'h00)) u_sec (
    .clk_i, .rst_ni, .inc_i(sec_tick_o), .lim_i(8'h59), .wr_i(wr_ok),
    .wr_sel_i(wsel), .wr_data_i(wr_data_i[7:0]), .val_o(sec_w), .carry_o(sec_c)
  );

  bcd_cal_wrap_cnt #(.SEL(F_MIN), .WMASK(8'h7F), .WRAPV(8'h00), .RSTV(8'h00)) u_min (
    .clk_i, .rst_ni, .inc_i(sec_c), .lim_i(8'h59), .wr_i(wr_ok),
    .wr_sel_i(wsel), .wr_data_i(wr_data_i[7:0]), .val_o(min_w), .carry_o(min_c)
  );

  bcd_cal_wrap_cnt #(.SEL(F_HOUR), .WMASK(8'h3F), .WRAPV(8'h00), .RSTV(8'h00)) u_hour (
    .clk_i, .rst_ni, .inc_i(min_c), .lim_i(8'h23), .wr_i(wr_ok),
    .wr_sel_i(wsel), .wr_data_i(wr_data_i[7:0]), .val_o(hour_w), .carry_o(hour_c)
  );

  bcd_cal_wrap_cnt #(.SEL(F_WDAY), .WMASK(8'h07), .WRAPV(8'h00), .RSTV(8'h00)) u_wday (
    .clk_i, .rst_ni, .inc_i(hour_c), .lim_i(8'h06), .wr_i(wr_ok),
    .wr_sel_i(wsel), .wr_data_i(wr_data_i[7:0]), .val_o(wday_w), .carry_o(wday_c)
  );

  bcd_cal_wrap_cnt #(.SEL(F_MDAY), .WMASK(8'h3F), .WRAPV(8'h01), .RSTV(8'h01)) u_mday (
    .clk_i, .rst_ni, .inc_i(hour_c), .lim_i(mday_lim), .wr_i(wr_ok),
    .wr_sel_i(wsel), .wr_data_i(wr_data_i[7:0]), .val_o(mday_w), .carry_o(mday_c)
  );

  bcd_cal_wrap_cnt #(.SEL(F_MON), .WMASK(8'h1F), .WRAPV(8'h01), .RSTV(8'h01)) u_mon (
    .clk_i, .rst_ni, .inc_i(mday_c), .lim_i(8'h12), .wr_i(wr_ok),
    .wr_sel_i(wsel), .wr_data_i(wr_data_i[7:0]), .val_o(mon_w), .carry_o(mon_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       year_q <= 12'h000;
    else if (wr_ok && wsel == F_YEAR)  year_q <= wr_data_i;
    else if (mon_c)                    year_q <= bcd3_inc(year_q);
  end

  always_comb begin
    case (field_e'(rd_sel_i))
      F_SEC:   rd_data_o = {4'h0, sec_w};
      F_MIN:   rd_data_o = {4'h0, min_w};
      F_HOUR:  rd_data_o = {4'h0, hour_w};
      F_WDAY:  rd_data_o = {4'h0, wday_w};
      F_MDAY:  rd_data_o = {4'h0, mday_w};
      F_MON:   rd_data_o = {4'h0, mon_w};
      F_YEAR:  rd_data_o = year_q;
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        enable_i,
  input logic        wr_en_i,
  input logic [2:0]  wr_sel_i,
  input logic [11:0] wr_data_i,
  input logic        sec_tick_o,
  input logic [7:0]  sec_i,
  input logic [7:0]  min_i,
  input logic [7:0]  hour_i,
  input logic [7:0]  wday_i,
  input logic [7:0]  mday_i,
  input logic [7:0]  mon_i,
  input logic [11:0] year_i,
  input logic        wday_carry_i
);
  p_tick_needs_enable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> $past(enable_i));

  p_tick_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);

  p_sec_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_o && !wr_en_i && sec_i == 8'h59) |=> (sec_i == 8'h00));

  p_wday_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wday_carry_i && !wr_en_i) |=> (wday_i == 8'h00));

  p_new_year_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_o && !wr_en_i && mon_i == 8'h12 && mday_i == 8'h31 &&
     hour_i == 8'h23 && min_i == 8'h59 && sec_i == 8'h59)
    |=> (mon_i == 8'h01 && mday_i == 8'h01 && hour_i == 8'h00));

  p_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !sec_tick_o) |=>
      ($stable(sec_i) && $stable(min_i) && $stable(hour_i) && $stable(wday_i) &&
       $stable(mday_i) && $stable(mon_i) && $stable(year_i)));

  p_write_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && wr_en_i && wr_sel_i == 3'd0) |=> (sec_i == ($past(wr_data_i[7:0]) & 8'h7F)));
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .wr_data_i    (wr_data_i),
  .sec_tick_o   (sec_tick_o),
  .sec_i        (sec_w),
  .min_i        (min_w),
  .hour_i       (hour_w),
  .wday_i       (wday_w),
  .mday_i       (mday_w),
  .mon_i        (mon_w),
  .year_i       (year_q),
  .wday_carry_i (wday_c)
);

// File: tb/tb_bcd_calendar.sv
`timescale 1ns/1ps
module tb_bcd_calendar;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [11:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [11:0] rd_data;
  logic        tick;

  bcd_calendar #(.DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .sec_tick_o(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int ms, mm, mh, mw, md, mo, my;

  function automatic logic [11:0] bcd8(input int v);
    return 12'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [11:0] bcdy(input int y);
    return 12'(((y / 100) << 8)) | bcd8(y % 100);
  endfunction

  function automatic bit leap(input int off);
    int y;
    y = off + 1900;
    return (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
  endfunction

  function automatic int dim(input int mon, input int off);
    case (mon)
      2:           return leap(off) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default:     return 31;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int sel, output logic [11:0] v);
    rd_sel = 3'(sel);
    #0.2;
    v = rd_data;
  endtask

  task automatic check_all(input string tag);
    logic [11:0] v;
    rd(0, v); chk({tag, " sec"},  v, bcd8(ms));
    rd(1, v); chk({tag, " min"},  v, bcd8(mm));
    rd(2, v); chk({tag, " hour"}, v, bcd8(mh));
    rd(3, v); chk({tag, " wday"}, v, bcd8(mw));
    rd(4, v); chk({tag, " mday"}, v, bcd8(md));
    rd(5, v); chk({tag, " mon"},  v, bcd8(mo));
    rd(6, v); chk({tag, " year"}, v, bcdy(my));
  endtask

  task automatic model_step();
    ms++;
    if (ms >= 60) begin
      ms = 0; mm++;
      if (mm >= 60) begin
        mm = 0; mh++;
        if (mh >= 24) begin
          mh = 0;
          mw = (mw >= 6) ? 0 : mw + 1;
          if (md >= dim(mo, my)) begin
            md = 1; mo++;
            if (mo > 12) begin
              mo = 1;
              my = (my >= 999) ? 0 : my + 1;
            end
          end else md++;
        end
      end
    end
  endtask

  // Restarts the prescaler and loads all fields well before the next strobe.
  task automatic set_time(input int s, input int m, input int h, input int w,
                          input int d, input int mon, input int y);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    for (int i = 0; i < 7; i++) begin
      wr_en  = 1'b1;
      wr_sel = 3'(i);
      case (i)
        0: wr_data = bcd8(s);
        1: wr_data = bcd8(m);
        2: wr_data = bcd8(h);
        3: wr_data = bcd8(w);
        4: wr_data = bcd8(d);
        5: wr_data = bcd8(mon);
        default: wr_data = bcdy(y);
      endcase
      @(negedge clk);
    end
    wr_en = 1'b0;
    ms = s; mm = m; mh = h; mw = w; md = d; mo = mon; my = y;
  endtask

  task automatic step_sec();
    int guard;
    guard = 0;
    while (!tick && guard < 4 * DIV) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    model_step();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int yl[8] = '{0, 100, 104, 101, 99, 200, 500, 999};
    logic [11:0] v;
    int cnt;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    ms = 0; mm = 0; mh = 0; mw = 0; md = 1; mo = 1; my = 0;
    check_all("R9");
    chk("R9 tick", 12'(tick), 12'h0);
    rd(7, v); chk("R6 unused select", v, 12'h000);

    // R1: strobe spacing after enable rises, then steady period
    enable = 1'b1;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!tick && cnt < 100);
    chk("R1 first strobe delay", 12'(cnt), 12'(DIV));
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!tick && cnt < 100);
    chk("R1 strobe period", 12'(cnt), 12'(DIV));
    @(negedge clk);

    // R7: frozen while disabled, writes discarded
    set_time(10, 20, 5, 2, 15, 6, 123);
    enable = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 12'h033;
    @(negedge clk);
    wr_sel = 3'd6; wr_data = 12'h456;
    @(negedge clk);
    wr_en = 1'b0;
    cnt = 0;
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    chk("R1 no strobe while disabled", 12'(cnt), 12'h0);
    check_all("R7");

    // R6: field masks and code 7 ignored
    set_time(0, 0, 0, 0, 1, 1, 0);
    enable = 1'b1;
    wr_en = 1'b1; wr_sel = 3'd3; wr_data = 12'hFFD;
    @(negedge clk);
    wr_sel = 3'd7; wr_data = 12'h777;
    @(negedge clk);
    wr_en = 1'b0;
    rd(3, v); chk("R6 wday mask", v, 12'h005);
    rd(7, v); chk("R6 code 7 read", v, 12'h000);
    mw = 5;
    check_all("R6");

    // R8: write coincident with strobe wins
    set_time(10, 30, 4, 1, 2, 3, 50);
    while (!tick) @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 12'h042;
    @(negedge clk);
    wr_en = 1'b0;
    rd(0, v); chk("R8 sec", v, 12'h042);
    rd(1, v); chk("R8 min", v, 12'h030);

    // R2: continuous run from midnight, just over an hour
    set_time(0, 0, 0, 0, 1, 1, 0);
    for (int i = 0; i < 3665; i++) begin
      step_sec();
      check_all("R2");
    end

    // R4/R5: month ends and February 28 over several year offsets
    foreach (yl[k]) begin
      for (int mn = 1; mn <= 12; mn++) begin
        set_time(59, 59, 23, 3, dim(mn, yl[k]), mn, yl[k]);
        step_sec();
        check_all("R5");
      end
      set_time(59, 59, 23, 4, 28, 2, yl[k]);
      step_sec();
      check_all("R4");
    end

    // R3: consecutive day ends across a leap February
    set_time(59, 59, 23, 5, 27, 2, 96);
    for (int i = 0; i < 10; i++) begin
      set_time(59, 59, 23, mw, md, mo, my);
      step_sec();
      check_all("R3");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule